// File: doc/BRIEF.md
# Counter-Based Next-Address Unit

This block supplies the instruction fetch address of a pipelined 32-bit RISC core. The address lives in a 19-bit register that behaves as a loadable counter. Straight-line code advances it by one each cycle. A taken control transfer instead loads it through a parallel load path.

The value that is loaded comes from a single adder whose two operands are chosen by multiplexers. A conditional branch adds a sign-extended offset to the current address. An absolute jump adds the jump target field to zero.

The load fires in either of two cases. The first is a branch-on-equal whose two register operands compare equal. The second is an asserted jump control bit. A stall input freezes the address. A synchronous reset returns it to zero.

Top module: `next_addr_unit`

## Requirements
- R1: When reset, stall, jump and a taken branch are all absent, `fetch_addr` advances by exactly one at the next rising clock edge.
- R2: When `br_eq_op` is 1, `jmp_op` is 0 and `cmp_a` equals `cmp_b` (all 32 bits), the next `fetch_addr` is the current address plus `br_offset`. `br_offset` is a 16-bit two's-complement value, sign-extended to 19 bits.
- R3: When `jmp_op` is 1, the next `fetch_addr` equals `jmp_target`, as an absolute address.
- R4: A branch is not taken, and the address advances by one, when `br_eq_op` is 1 but the operands differ. The same holds when the operands are equal but `br_eq_op` is 0.
- R5: While `stall` is 1, `fetch_addr` keeps its value, whatever the branch and jump inputs are.
- R6: `rst` is synchronous and active high, and it sets `fetch_addr` to 0 at the next edge. It overrides `stall` and every control input.
- R7: If `jmp_op` and a taken branch occur in the same cycle, the absolute jump target is loaded.
- R8: All address arithmetic wraps modulo 2^19. Incrementing 0x7FFFF gives 0, and a branch below address 0 wraps to the top of the space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze the fetch address |
| br_eq_op | input | 1 | Current instruction is branch-on-equal |
| jmp_op | input | 1 | Current instruction is an absolute jump |
| cmp_a | input | 32 | First register operand of the comparison |
| cmp_b | input | 32 | Second register operand of the comparison |
| br_offset | input | 16 | Signed branch offset in words |
| jmp_target | input | 19 | Absolute jump target address |
| fetch_addr | output | 19 | Current instruction address |

## Verification
The embedded properties check every cycle that a stall holds the address. They also check that reset yields zero, that an idle cycle steps by one, and that a jump or a taken equal-branch lands on its computed target.

Some cases are shown only by the bench's scenarios. These are the wrap-around at both ends of the 19-bit space and the branch that is declined for unequal operands or a missing branch bit. They also include jump-over-branch priority, and reset taking effect during a stall.

// File: rtl/next_addr_unit.sv
module next_addr_unit #(
  parameter int AW   = 19,
  parameter int DW   = 32,
  parameter int OFFW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic          br_eq_op,
  input  logic          jmp_op,
  input  logic [DW-1:0] cmp_a,
  input  logic [DW-1:0] cmp_b,
  input  logic [OFFW-1:0] br_offset,
  input  logic [AW-1:0] jmp_target,
  output logic [AW-1:0] fetch_addr
);
  localparam int EXT = AW - OFFW;

  logic [AW-1:0] addr_q;
  logic [AW-1:0] off_ext;
  logic [AW-1:0] op_lhs;
  logic [AW-1:0] op_rhs;
  logic [AW-1:0] load_val;
  logic          ops_equal;
  logic          load_en;

  assign off_ext   = {{EXT{br_offset[OFFW-1]}}, br_offset};
  assign op_lhs    = jmp_op ? '0 : addr_q;
  assign op_rhs    = jmp_op ? jmp_target : off_ext;
  assign load_val  = op_lhs + op_rhs;
  assign ops_equal = (cmp_a == cmp_b);
  assign load_en   = (br_eq_op & ops_equal) | jmp_op;

  always_ff @(posedge clk) begin
    if (rst)           addr_q <= '0;
    else if (!stall) begin
      if (load_en)     addr_q <= load_val;
      else             addr_q <= addr_q + AW'(1);
    end
  end

  assign fetch_addr = addr_q;

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> fetch_addr == '0); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> fetch_addr == $past(fetch_addr)); // R5
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!stall && !jmp_op && !(br_eq_op && cmp_a == cmp_b))
      |=> fetch_addr == AW'($past(fetch_addr) + AW'(1))); // R1
  AST_JUMP_ABS: assert property (@(posedge clk) disable iff (rst)
    (!stall && jmp_op) |=> fetch_addr == $past(jmp_target)); // R3
  AST_BRANCH_REL: assert property (@(posedge clk) disable iff (rst)
    (!stall && !jmp_op && br_eq_op && cmp_a == cmp_b)
      |=> fetch_addr == AW'($past(fetch_addr) + AW'($signed($past(br_offset))))); // R2
endmodule

// File: tb/next_addr_unit_bench.sv
module next_addr_unit_bench;
  localparam int AW = 19;
  logic clk = 0;
  logic rst = 1, stall = 0, br_eq_op = 0, jmp_op = 0;
  logic [31:0] cmp_a = 0, cmp_b = 0;
  logic [15:0] br_offset = 0;
  logic [AW-1:0] jmp_target = 0;
  logic [AW-1:0] fetch_addr;

  next_addr_unit u_next_addr_unit (.*);

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  logic [AW-1:0] exp_q[$];
  string         tag_q[$];
  logic [AW-1:0] mpc = 0;

  task automatic drive(input logic r, input logic s, input logic be, input logic j,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] off, input logic [AW-1:0] tgt, input string tag);
    @(negedge clk);
    rst = r; stall = s; br_eq_op = be; jmp_op = j;
    cmp_a = a; cmp_b = b; br_offset = off; jmp_target = tgt;
    if (r) mpc = 0;
    else if (!s) begin
      if (j) mpc = tgt;
      else if (be && a == b) mpc = mpc + AW'({{3{off[15]}}, off});
      else mpc = mpc + 1;
    end
    exp_q.push_back(mpc);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [AW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compared++;
      if (fetch_addr !== e) begin
        mismatched++;
        $display("FAIL %s: fetch_addr=%h expected=%h", t, fetch_addr, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    drive(1, 0, 0, 0, 0, 0, 0, 0, "R6 reset");
    drive(1, 0, 0, 1, 0, 0, 0, 19'h1234, "R6 reset over jump");
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, "R1 sequential step");
    drive(0, 0, 1, 0, 32'hA5A5_0001, 32'hA5A5_0001, 16'd10, 0, "R2 branch forward");
    drive(0, 0, 1, 0, 7, 7, 16'hFFFD, 0, "R2 branch backward");
    drive(0, 0, 1, 0, 32'h8000_0000, 0, 16'd100, 0, "R4 unequal operands");
    drive(0, 0, 0, 0, 5, 5, 16'd100, 0, "R4 equal without branch bit");
    drive(0, 0, 0, 1, 1, 2, 16'd7, 19'h2_0000, "R3 absolute jump");
    drive(0, 0, 1, 1, 3, 3, 16'd50, 19'h0_0100, "R7 jump beats branch");
    drive(0, 1, 0, 1, 0, 0, 0, 19'h5_5555, "R5 stall blocks jump");
    drive(0, 1, 1, 0, 9, 9, 16'd20, 0, "R5 stall blocks branch");
    drive(0, 1, 0, 0, 0, 0, 0, 0, "R5 stall blocks step");
    drive(0, 0, 0, 1, 0, 0, 0, 19'h7_FFFF, "R3 jump to top");
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R8 increment wraps");
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R1 step after wrap");
    drive(0, 0, 1, 0, 0, 0, 16'hFFFB, 0, "R8 branch below zero wraps");
    drive(0, 0, 1, 0, 0, 0, 16'h0008, 0, "R8 branch past top wraps");
    drive(1, 1, 1, 1, 0, 0, 16'd4, 19'h0_0777, "R6 reset during stall");
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R1 step after reset");
    @(negedge clk);
    rst = 0; stall = 0; br_eq_op = 0; jmp_op = 0;
    while (exp_q.size() > 0) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule